// File: doc/BRIEF.md
# Vector Configuration Tracker with Decode Stall

This block belongs in an instruction decode stage. It holds the active vector configuration: element width, register grouping multiplier, vector length, the maximum vector length derived from them, and the tail-agnostic flag. Each cycle decode may offer one instruction. The instruction carries a kind code, its rs1 and rd register indices, and the configuration fields decoded from it. The block accepts the instruction and forwards it one cycle later.

Set-configuration instructions fall into two groups. Some can be applied in decode, and the block applies them there. The others depend on a register value that only execute can read. For those, the block forwards the set instruction marked as needing a resolve, then holds decode until execute returns the resolved configuration. A flush drops a pending hold.

Ordinary vector instructions leave with a copy of the configuration that is active when they are decoded. An error flag reports an illegal multiplier or a vector length larger than the maximum.

Top module: `vcfg_tracker`

## Requirements
- R1: After reset the configuration is vector length 16, element width 8, multiplier 1, maximum length 16, and tail-undisturbed (`cur_vta`=0). The block is not stalled, `in_ready`=1 and `out_valid`=0.
- R2: Maximum vector length equals (VLEN / element width) × multiplier. It is recomputed in the same update that changes the width or the multiplier.
- R3: An accepted immediate-form set (kind 2) loads width, multiplier, tail flag and vector length from its inputs. It never stalls.
- R4: An accepted register-immediate set (kind 3) with rs1 = 0 and rd ≠ 0 loads width, multiplier and tail flag. It sets vector length to the new maximum and does not stall.
- R5: An accepted kind 3 with rs1 = 0 and rd = 0 keeps the old vector length, clamped to at most the new maximum. It does not stall.
- R6: An accepted kind 3 with rs1 ≠ 0, or any accepted full register set (kind 4), is forwarded with `out_need_resolve`=1. It leaves the configuration unchanged and stalls: `in_ready` goes to 0.
- R7: While stalled, offered instructions are not accepted, `out_valid` stays 0 and the configuration holds. A `res_valid` pulse loads the resolved configuration and releases the stall.
- R8: `flush` clears a pending stall. It discards any instruction offered in the same cycle, so no output follows, and it leaves the configuration unchanged.
- R9: A forwarded other-vector instruction (kind 1) has `out_tag`=1 and carries the configuration active when it was accepted. Every other kind has `out_tag`=0 and zero configuration fields.
- R10: `cfg_err` is 1 exactly when the multiplier is above 8 or the vector length is above the maximum.
- R11: Each accepted instruction appears on `out_valid` and `out_kind` one cycle after acceptance, for one cycle. Kind codes: 0 scalar, 1 other vector, 2 immediate-form set, 3 register-immediate set, 4 full register set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop pending stall and same-cycle input |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Not stalled; instruction accepted when valid |
| in_kind | input | 3 | Kind code (see R11) |
| in_rs1 | input | RIDX | rs1 index |
| in_rd | input | RIDX | rd index |
| in_sew | input | SEWW | Decoded element width in bits |
| in_lmul | input | LMW | Decoded multiplier (integer) |
| in_vl | input | VLW | Decoded vector length |
| in_vta | input | 1 | Decoded tail-agnostic flag |
| res_valid | input | 1 | Execute returns the resolved configuration |
| res_sew | input | SEWW | Resolved element width |
| res_lmul | input | LMW | Resolved multiplier |
| res_vl | input | VLW | Resolved vector length |
| res_vta | input | 1 | Resolved tail flag |
| out_valid | output | 1 | Forwarded instruction valid |
| out_kind | output | 3 | Forwarded kind |
| out_need_resolve | output | 1 | Set instruction waiting for execute |
| out_tag | output | 1 | Configuration snapshot attached |
| out_sew | output | SEWW | Snapshot element width |
| out_lmul | output | LMW | Snapshot multiplier |
| out_vl | output | VLW | Snapshot vector length |
| out_vta | output | 1 | Snapshot tail flag |
| cur_sew | output | SEWW | Active element width |
| cur_lmul | output | LMW | Active multiplier |
| cur_vl | output | VLW | Active vector length |
| cur_vlmax | output | VLW | Active maximum length |
| cur_vta | output | 1 | Active tail flag |
| cfg_err | output | 1 | Illegal configuration |

## Verification
A stuck or spurious stall shows up on `in_ready` in the cycle after the set instruction. It shows up again on `out_valid` one cycle later, when a following instruction fails to appear or appears when it should not. A wrong maximum length or a misapplied length rule shows on `cur_vlmax` and `cur_vl` right after the update edge. It also reaches the `out_vl` snapshot of the next vector instruction one cycle after that instruction is accepted. A flush that fails to clear the hold leaves `in_ready` low on the following cycle.

// File: rtl/vcfg_tracker.sv
module vcfg_tracker #(
  parameter int VLEN = 128,
  parameter int RIDX = 5,
  parameter int VLW  = 16,
  parameter int SEWW = 8,
  parameter int LMW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_kind,
  input  logic [RIDX-1:0] in_rs1,
  input  logic [RIDX-1:0] in_rd,
  input  logic [SEWW-1:0] in_sew,
  input  logic [LMW-1:0]  in_lmul,
  input  logic [VLW-1:0]  in_vl,
  input  logic            in_vta,
  input  logic            res_valid,
  input  logic [SEWW-1:0] res_sew,
  input  logic [LMW-1:0]  res_lmul,
  input  logic [VLW-1:0]  res_vl,
  input  logic            res_vta,
  output logic            out_valid,
  output logic [2:0]      out_kind,
  output logic            out_need_resolve,
  output logic            out_tag,
  output logic [SEWW-1:0] out_sew,
  output logic [LMW-1:0]  out_lmul,
  output logic [VLW-1:0]  out_vl,
  output logic            out_vta,
  output logic [SEWW-1:0] cur_sew,
  output logic [LMW-1:0]  cur_lmul,
  output logic [VLW-1:0]  cur_vl,
  output logic [VLW-1:0]  cur_vlmax,
  output logic            cur_vta,
  output logic            cfg_err
);
  localparam logic [2:0] K_VEC   = 3'd1;
  localparam logic [2:0] K_SETI  = 3'd2;
  localparam logic [2:0] K_SETRI = 3'd3;
  localparam logic [2:0] K_SETR  = 3'd4;
  localparam logic [VLW-1:0] RST_VL = VLW'(16);
  localparam logic [SEWW-1:0] RST_SEW = SEWW'(8);

  function automatic logic [VLW-1:0] vmax(input logic [SEWW-1:0] s, input logic [LMW-1:0] m);
    if (s == '0) return '0;
    return VLW'((VLEN / int'(s)) * int'(m));
  endfunction

  logic stalled;
  logic accept;
  logic [VLW-1:0] new_max;
  logic [VLW-1:0] kept_vl;

  assign in_ready = !stalled;
  assign accept   = in_valid && !stalled && !flush;
  assign new_max  = vmax(in_sew, in_lmul);
  assign kept_vl  = (cur_vl < new_max) ? cur_vl : new_max;
  assign cfg_err  = (cur_lmul > LMW'(8)) || (cur_vl > cur_vlmax);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled <= 1'b0;
      out_valid <= 1'b0;
      out_kind <= '0;
      out_need_resolve <= 1'b0;
      out_tag <= 1'b0;
      out_sew <= '0;
      out_lmul <= '0;
      out_vl <= '0;
      out_vta <= 1'b0;
      cur_sew <= RST_SEW;
      cur_lmul <= LMW'(1);
      cur_vl <= RST_VL;
      cur_vlmax <= vmax(RST_SEW, LMW'(1));
      cur_vta <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (flush) begin
        stalled <= 1'b0;
      end else if (stalled) begin
        if (res_valid) begin
          stalled <= 1'b0;
          cur_sew <= res_sew;
          cur_lmul <= res_lmul;
          cur_vl <= res_vl;
          cur_vlmax <= vmax(res_sew, res_lmul);
          cur_vta <= res_vta;
        end
      end else if (in_valid) begin
        out_valid <= 1'b1;
        out_kind <= in_kind;
        out_need_resolve <= 1'b0;
        out_tag <= (in_kind == K_VEC);
        out_sew <= (in_kind == K_VEC) ? cur_sew : '0;
        out_lmul <= (in_kind == K_VEC) ? cur_lmul : '0;
        out_vl <= (in_kind == K_VEC) ? cur_vl : '0;
        out_vta <= (in_kind == K_VEC) ? cur_vta : 1'b0;
        if (in_kind == K_SETI || (in_kind == K_SETRI && in_rs1 == '0)) begin
          cur_sew <= in_sew;
          cur_lmul <= in_lmul;
          cur_vlmax <= new_max;
          cur_vta <= in_vta;
          if (in_kind == K_SETI) cur_vl <= in_vl;
          else if (in_rd != '0) cur_vl <= new_max;
          else cur_vl <= kept_vl;
        end else if (in_kind == K_SETRI || in_kind == K_SETR) begin
          stalled <= 1'b1;
          out_need_resolve <= 1'b1;
        end
      end
    end
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !out_valid); // R7
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !res_valid) |=> ($stable(cur_vl) && $stable(cur_sew) && $stable(cur_lmul))); // R7
  AST_IMM_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_SETI) |=> (in_ready && out_valid && !out_need_resolve)); // R3
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_SETR) |=> (!in_ready && out_need_resolve)); // R6
  AST_RD_TAKES_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_SETRI && in_rs1 == '0 && in_rd != '0) |=> (cur_vl == cur_vlmax)); // R4
  AST_KEEP_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_SETRI && in_rs1 == '0 && in_rd == '0) |=> (cur_vl <= cur_vlmax)); // R5
  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (in_ready && !out_valid)); // R8
endmodule

// File: tb/vcfg_tracker_bench.sv
module vcfg_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_kind = '0;
  logic [4:0] in_rs1 = '0, in_rd = '0;
  logic [7:0] in_sew = '0;
  logic [3:0] in_lmul = '0;
  logic [15:0] in_vl = '0;
  logic in_vta = 1'b0;
  logic res_valid = 1'b0;
  logic [7:0] res_sew = '0;
  logic [3:0] res_lmul = '0;
  logic [15:0] res_vl = '0;
  logic res_vta = 1'b0;
  logic out_valid, out_need_resolve, out_tag, out_vta, cur_vta, cfg_err;
  logic [2:0] out_kind;
  logic [7:0] out_sew, cur_sew;
  logic [3:0] out_lmul, cur_lmul;
  logic [15:0] out_vl, cur_vl, cur_vlmax;
  int checks = 0;
  int errors = 0;

  vcfg_tracker u_vcfg_tracker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_rs1(in_rs1), .in_rd(in_rd), .in_sew(in_sew), .in_lmul(in_lmul),
    .in_vl(in_vl), .in_vta(in_vta), .res_valid(res_valid), .res_sew(res_sew),
    .res_lmul(res_lmul), .res_vl(res_vl), .res_vta(res_vta), .out_valid(out_valid),
    .out_kind(out_kind), .out_need_resolve(out_need_resolve), .out_tag(out_tag),
    .out_sew(out_sew), .out_lmul(out_lmul), .out_vl(out_vl), .out_vta(out_vta),
    .cur_sew(cur_sew), .cur_lmul(cur_lmul), .cur_vl(cur_vl), .cur_vlmax(cur_vlmax),
    .cur_vta(cur_vta), .cfg_err(cfg_err));

  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_is(input string req, input int s, input int m, input int v, input int mx, input int t);
    check(req, "cur_sew", int'(cur_sew), s);
    check(req, "cur_lmul", int'(cur_lmul), m);
    check(req, "cur_vl", int'(cur_vl), v);
    check(req, "cur_vlmax", int'(cur_vlmax), mx);
    check(req, "cur_vta", int'(cur_vta), t);
  endtask

  task automatic issue(input int k, input int r1, input int rd, input int s, input int m, input int v, input int t);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 3'(k); in_rs1 = 5'(r1); in_rd = 5'(rd);
    in_sew = 8'(s); in_lmul = 4'(m); in_vl = 16'(v); in_vta = 1'(t);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic resolve(input int s, input int m, input int v, input int t);
    @(negedge clk);
    res_valid = 1'b1; res_sew = 8'(s); res_lmul = 4'(m); res_vl = 16'(v); res_vta = 1'(t);
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    cfg_is("R1", 8, 1, 16, 16, 0);
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R10", "cfg_err reset", int'(cfg_err), 0);
  endtask

  task automatic t_immediate;
    issue(2, 7, 3, 32, 2, 6, 1);
    cfg_is("R3", 32, 2, 6, 8, 1);
    check("R2", "vlmax 128/32*2", int'(cur_vlmax), 8);
    check("R3", "in_ready", int'(in_ready), 1);
    check("R11", "out_valid", int'(out_valid), 1);
    check("R11", "out_kind", int'(out_kind), 2);
    check("R3", "need_resolve", int'(out_need_resolve), 0);
    @(posedge clk); #1;
    check("R11", "out_valid one cycle", int'(out_valid), 0);
  endtask

  task automatic t_snapshot;
    issue(1, 2, 4, 0, 0, 0, 0);
    check("R9", "out_tag", int'(out_tag), 1);
    check("R9", "out_sew", int'(out_sew), 32);
    check("R9", "out_lmul", int'(out_lmul), 2);
    check("R9", "out_vl", int'(out_vl), 6);
    check("R9", "out_vta", int'(out_vta), 1);
    issue(0, 2, 4, 0, 0, 0, 0);
    check("R9", "scalar tag", int'(out_tag), 0);
    check("R9", "scalar vl", int'(out_vl), 0);
    check("R11", "scalar kind", int'(out_kind), 0);
  endtask

  task automatic t_zero_rs1;
    issue(3, 0, 3, 16, 4, 99, 0);
    cfg_is("R4", 16, 4, 32, 32, 0);
    check("R4", "in_ready", int'(in_ready), 1);
    issue(3, 0, 0, 64, 1, 99, 0);
    cfg_is("R5", 64, 1, 2, 2, 0);
    issue(3, 0, 0, 8, 1, 99, 1);
    cfg_is("R5", 8, 1, 2, 16, 1);
    check("R5", "in_ready", int'(in_ready), 1);
  endtask

  task automatic t_stall;
    issue(4, 6, 2, 16, 2, 5, 0);
    check("R6", "need_resolve", int'(out_need_resolve), 1);
    check("R6", "out_valid", int'(out_valid), 1);
    check("R6", "in_ready", int'(in_ready), 0);
    cfg_is("R6", 8, 1, 2, 16, 1);
    issue(1, 1, 1, 0, 0, 0, 0);
    check("R7", "out_valid stalled", int'(out_valid), 0);
    issue(2, 0, 1, 64, 8, 3, 0);
    check("R7", "out_valid stalled", int'(out_valid), 0);
    cfg_is("R7", 8, 1, 2, 16, 1);
    resolve(8, 8, 100, 0);
    cfg_is("R7", 8, 8, 100, 128, 0);
    check("R7", "in_ready released", int'(in_ready), 1);
    issue(1, 1, 1, 0, 0, 0, 0);
    check("R9", "out_vl after resolve", int'(out_vl), 100);
    check("R7", "accepted after resolve", int'(out_valid), 1);
  endtask

  task automatic t_flush;
    issue(3, 9, 4, 32, 1, 4, 1);
    check("R6", "rs1 nonzero stalls", int'(in_ready), 0);
    check("R6", "need_resolve", int'(out_need_resolve), 1);
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    check("R8", "in_ready after flush", int'(in_ready), 1);
    cfg_is("R8", 8, 8, 100, 128, 0);
    @(negedge clk); flush = 1'b1;
    in_valid = 1'b1; in_kind = 3'd2; in_sew = 8'd64; in_lmul = 4'd1; in_vl = 16'd1;
    @(posedge clk); #1; flush = 1'b0; in_valid = 1'b0;
    check("R8", "dropped out_valid", int'(out_valid), 0);
    cfg_is("R8", 8, 8, 100, 128, 0);
  endtask

  task automatic t_error;
    issue(2, 0, 0, 8, 9, 10, 0);
    check("R10", "lmul 9", int'(cfg_err), 1);
    issue(2, 0, 0, 8, 1, 40, 0);
    check("R10", "vl over max", int'(cfg_err), 1);
    issue(2, 0, 0, 8, 1, 16, 0);
    check("R10", "vl at max", int'(cfg_err), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_immediate();
    t_snapshot();
    t_zero_rs1();
    t_stall();
    t_flush();
    t_error();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule